// File: doc/BRIEF.md
# Bus activity monitor with watermark interrupts

This block watches a single event strobe from a bus or memory port and turns it into a measure of load. Each cycle in which the strobe is high adds a programmable weight to a running period count. At the end of every sampling period the count becomes one sample, is folded into an exponential moving average, and is compared against two pairs of thresholds. The first pair looks at the raw sample and asks for a programmable number of consecutive periods on the same side. The second pair looks at the freshly updated average.

Each breach latches a bit in an interrupt status word. Software clears those bits by writing ones to them. The interrupt line is the registered OR of the latched bits whose checks are enabled. A clock-rate or load governor reads the average and moves the thresholds after each interrupt.

The sampling period is a whole number of time units, each `UNIT_CYCLES` clocks long. The period register and both consecutive-count fields hold their value minus one. Registers are reached through a word-addressed port with a one-cycle read latency.

Top module: `bus_activity_monitor`

## Requirements
- R1: After reset every register reads zero, including control, weight, average and status, and `irq` is low.
- R2: Word addresses are: 0 control, 1 sample upper threshold, 2 sample lower threshold, 3 average load (write only), 4 average upper threshold, 5 average lower threshold, 6 event weight, 7 average (read only), 8 status, 9 period. A write takes effect at the clock edge on which `reg_wr` is high. A read puts the value on `reg_rdata` at the edge on which `reg_rd` is high.
- R3: Sampling runs while control bit 31 (master enable) and bit 18 (periodic sampling) are both set. A period lasts (period+1)·UNIT_CYCLES cycles, counted from the edge that set the enables. Its sample is weight × the number of cycles with `event_in` high, including the last cycle of the period. The count then restarts from zero.
- R4: The period count saturates at 2^CNT_W−1 and does not wrap.
- R5: At each sample the average becomes avg + ((sample − avg) >>> (K+1)), using signed arithmetic. K is control bits 12:10, so the window is 2^(K+1) samples.
- R6: Writing address 3 loads the average directly. A load wins over an update in the same cycle.
- R7: When control bit 30 is set, a sample strictly above the upper threshold in N consecutive periods sets status bit 31. N is control bits 28:26 plus one. The run counter then restarts.
- R8: When control bit 29 is set, a sample strictly below the lower threshold in N consecutive periods sets status bit 30. N is control bits 25:23 plus one. Any sample that is not below the threshold restarts the run.
- R9: When control bit 21 is set, a new average strictly above the average upper threshold sets status bit 29. When control bit 20 is set, a new average strictly below the average lower threshold sets status bit 28.
- R10: A write to status clears the bits written as one; a set in the same cycle wins. `irq` is high one cycle after any status bit whose enable (bits 31, 30, 29, 28 paired with control bits 30, 29, 21, 20) is set, and low one cycle after none is.
- R11: Clearing control bit 31, for example by writing zero, stops sampling. It discards the partial count and empties both consecutive-run counters, and a later enable starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| event_in | input | 1 | Activity strobe, one weighted event per high cycle |
| irq | output | 1 | Registered interrupt request |

## Verification
Take the edge that writes the enables as edge 0. The sample of period n is registered at edge n·L, where L is (period+1)·UNIT_CYCLES. The average and the status bits change at edge n·L+1, and `irq` follows at edge n·L+2. The bench counts edges from the enable write, samples one time unit after each edge, and checks `irq` on both sides of its due edge. Before the channel is stopped, each scenario lets the last wanted period land and then stops before the next period ends, so every average and status word read back has an exact expected value.

// File: rtl/amon_pkg.sv
package amon_pkg;
  localparam int REG_W = 32;

  // control word bit positions
  localparam int C_MASTER  = 31;
  localparam int C_UP_EN   = 30;
  localparam int C_DN_EN   = 29;
  localparam int C_UP_N_LO = 26;
  localparam int C_DN_N_LO = 23;
  localparam int C_AHI_EN  = 21;
  localparam int C_ALO_EN  = 20;
  localparam int C_PERIOD  = 18;
  localparam int C_K_LO    = 10;
  localparam int RUN_N_W   = 3;
  localparam int K_W       = 3;

  // status bit positions
  localparam int S_UP  = 31;
  localparam int S_DN  = 30;
  localparam int S_AHI = 29;
  localparam int S_ALO = 28;

  // word addresses
  localparam int A_CTRL   = 0;
  localparam int A_UPWM   = 1;
  localparam int A_LOWM   = 2;
  localparam int A_AVGLD  = 3;
  localparam int A_AHI    = 4;
  localparam int A_ALO    = 5;
  localparam int A_WGT    = 6;
  localparam int A_AVG    = 7;
  localparam int A_STAT   = 8;
  localparam int A_PERIOD = 9;

  typedef struct packed {
    logic                master;
    logic                up_en;
    logic                dn_en;
    logic [RUN_N_W-1:0]  up_lim;
    logic [RUN_N_W-1:0]  dn_lim;
    logic                ahi_en;
    logic                alo_en;
    logic                periodic;
    logic [K_W-1:0]      k;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.master   = w[C_MASTER];
    c.up_en    = w[C_UP_EN];
    c.dn_en    = w[C_DN_EN];
    c.up_lim   = w[C_UP_N_LO +: RUN_N_W];
    c.dn_lim   = w[C_DN_N_LO +: RUN_N_W];
    c.ahi_en   = w[C_AHI_EN];
    c.alo_en   = w[C_ALO_EN];
    c.periodic = w[C_PERIOD];
    c.k        = w[C_K_LO +: K_W];
    return c;
  endfunction
endpackage

// File: rtl/amon_period_timer.sv
module amon_period_timer #(
  parameter int UNIT_CYCLES = 1000,
  parameter int PER_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PER_W-1:0] per_lim,
  output logic             period_end
);
  localparam int UW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [UW-1:0] UNIT_LAST = UW'(UNIT_CYCLES - 1);

  logic [UW-1:0]    unit_cnt;
  logic [PER_W-1:0] per_cnt;
  logic             unit_wrap;

  assign unit_wrap  = run && (unit_cnt >= UNIT_LAST);
  assign period_end = unit_wrap && (per_cnt >= per_lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      unit_cnt <= '0;
      per_cnt  <= '0;
    end else if (unit_wrap) begin
      unit_cnt <= '0;
      if (per_cnt >= per_lim) per_cnt <= '0;
      else                    per_cnt <= per_cnt + 1'b1;
    end else begin
      unit_cnt <= unit_cnt + 1'b1;
    end
  end

  // R3: the unit counter never runs past its last value
  a_r3_unit_bound: assert property (@(posedge clk) disable iff (rst)
    unit_cnt <= UNIT_LAST);
endmodule

// File: rtl/amon_accum.sv
module amon_accum #(
  parameter int CNT_W = 32,
  parameter int WGT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             event_in,
  input  logic [WGT_W-1:0] weight,
  input  logic             period_end,
  output logic [CNT_W-1:0] sample_q,
  output logic             sample_vld_q
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] count_next;

  always_comb begin
    sum = {1'b0, count_q} + ((run && event_in) ? (CNT_W+1)'(weight) : '0);
    count_next = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q      <= '0;
      sample_q     <= '0;
      sample_vld_q <= 1'b0;
    end else begin
      sample_vld_q <= period_end;
      if (!run) begin
        count_q <= '0;
      end else if (period_end) begin
        sample_q <= count_next;
        count_q  <= '0;
      end else begin
        count_q <= count_next;
      end
    end
  end

  // R4: inside a period the count only grows (saturates, never wraps)
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && !period_end) |=> (count_q >= $past(count_q)));

  // R3: a sample is only produced from a running channel
  a_r3_sample_when_running: assert property (@(posedge clk) disable iff (rst)
    sample_vld_q |-> $past(run));
endmodule

// File: rtl/amon_ema.sv
module amon_ema #(
  parameter int CNT_W = 32,
  parameter int K_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [CNT_W-1:0] sample,
  input  logic [K_W-1:0]   k,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] hi_wm,
  input  logic [CNT_W-1:0] lo_wm,
  output logic [CNT_W-1:0] avg_q,
  output logic             hi_hit,
  output logic             lo_hit
);
  logic signed [CNT_W:0] diff;
  logic signed [CNT_W:0] step;
  logic signed [CNT_W:0] sum;
  logic [K_W:0]          shamt;
  logic [CNT_W-1:0]      avg_next;

  always_comb begin
    shamt    = {1'b0, k} + 1'b1;
    diff     = $signed({1'b0, sample}) - $signed({1'b0, avg_q});
    step     = diff >>> shamt;
    sum      = $signed({1'b0, avg_q}) + step;
    avg_next = sum[CNT_W] ? '0 : sum[CNT_W-1:0];
    hi_hit   = vld && (avg_next > hi_wm);
    lo_hit   = vld && (avg_next < lo_wm);
  end

  always_ff @(posedge clk) begin
    if (rst)      avg_q <= '0;
    else if (ld)  avg_q <= ld_val;
    else if (vld) avg_q <= avg_next;
  end

  // R5: an update moves the average toward the sample and never past it
  a_r5_toward_sample: assert property (@(posedge clk) disable iff (rst)
    (vld && !ld) |=> ((avg_q >= $past(avg_q) && avg_q <= $past(sample)) ||
                      (avg_q <= $past(avg_q) && avg_q >= $past(sample))));

  // R6: a load lands exactly
  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    ld |=> (avg_q == $past(ld_val)));
endmodule

// File: rtl/amon_run_counter.sv
module amon_run_counter #(
  parameter int N_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           vld,
  input  logic           hit,
  input  logic [N_W-1:0] lim,
  output logic           fire
);
  logic [N_W-1:0] cnt_q;

  assign fire = en && vld && hit && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (vld) begin
      if (!hit || fire) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7/R8: the run restarts after each interrupt
  a_r7_restart_after_fire: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cnt_q == '0));

  // R11: a disabled check holds no partial run
  a_r11_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (cnt_q == '0));
endmodule

// File: rtl/bus_activity_monitor.sv
module bus_activity_monitor
  import amon_pkg::*;
#(
  parameter int UNIT_CYCLES = 1000,
  parameter int PER_W       = 8,
  parameter int CNT_W       = 32,
  parameter int WGT_W       = 16,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              event_in,
  output logic              irq
);
  localparam int N_DIR = 2;
  localparam int ST_W  = 4;

  logic [REG_W-1:0] ctrl_q;
  logic [CNT_W-1:0] up_wm_q, lo_wm_q, ahi_q, alo_q;
  logic [WGT_W-1:0] wgt_q;
  logic [PER_W-1:0] per_q;
  logic [ST_W-1:0]  stat_q;   // [3]=bit31 .. [0]=bit28

  ctrl_t            c;
  logic             run;
  logic             period_end;
  logic [CNT_W-1:0] sample;
  logic             sample_vld;
  logic [CNT_W-1:0] avg;
  logic             ahi_hit, alo_hit;
  logic             avg_ld;
  logic [ST_W-1:0]  st_set, st_clr, st_en;

  logic [N_DIR-1:0]         dir_en, dir_hit, dir_fire;
  logic [RUN_N_W-1:0]       dir_lim [N_DIR];

  function automatic logic wr_at(input logic [ADDR_W-1:0] a, input int idx);
    return (a == ADDR_W'(idx));
  endfunction

  assign c      = decode_ctrl(ctrl_q);
  assign run    = c.master && c.periodic;
  assign avg_ld = reg_wr && wr_at(reg_addr, A_AVGLD);

  // ---------------- register file ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      up_wm_q <= '0;
      lo_wm_q <= '0;
      ahi_q   <= '0;
      alo_q   <= '0;
      wgt_q   <= '0;
      per_q   <= '0;
    end else if (reg_wr) begin
      if (wr_at(reg_addr, A_CTRL))   ctrl_q  <= reg_wdata;
      if (wr_at(reg_addr, A_UPWM))   up_wm_q <= reg_wdata[CNT_W-1:0];
      if (wr_at(reg_addr, A_LOWM))   lo_wm_q <= reg_wdata[CNT_W-1:0];
      if (wr_at(reg_addr, A_AHI))    ahi_q   <= reg_wdata[CNT_W-1:0];
      if (wr_at(reg_addr, A_ALO))    alo_q   <= reg_wdata[CNT_W-1:0];
      if (wr_at(reg_addr, A_WGT))    wgt_q   <= reg_wdata[WGT_W-1:0];
      if (wr_at(reg_addr, A_PERIOD)) per_q   <= reg_wdata[PER_W-1:0];
    end
  end

  // ---------------- datapath ----------------
  amon_period_timer #(.UNIT_CYCLES(UNIT_CYCLES), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .run(run), .per_lim(per_q), .period_end(period_end)
  );

  amon_accum #(.CNT_W(CNT_W), .WGT_W(WGT_W)) u_accum (
    .clk(clk), .rst(rst), .run(run), .event_in(event_in), .weight(wgt_q),
    .period_end(period_end), .sample_q(sample), .sample_vld_q(sample_vld)
  );

  amon_ema #(.CNT_W(CNT_W), .K_W(K_W)) u_ema (
    .clk(clk), .rst(rst), .vld(sample_vld), .sample(sample), .k(c.k),
    .ld(avg_ld), .ld_val(reg_wdata[CNT_W-1:0]), .hi_wm(ahi_q), .lo_wm(alo_q),
    .avg_q(avg), .hi_hit(ahi_hit), .lo_hit(alo_hit)
  );

  // direction 0: above upper threshold, direction 1: below lower threshold
  assign dir_en[0]  = c.master && c.up_en;
  assign dir_en[1]  = c.master && c.dn_en;
  assign dir_hit[0] = sample > up_wm_q;
  assign dir_hit[1] = sample < lo_wm_q;
  assign dir_lim[0] = c.up_lim;
  assign dir_lim[1] = c.dn_lim;

  for (genvar d = 0; d < N_DIR; d++) begin : g_run
    amon_run_counter #(.N_W(RUN_N_W)) u_run (
      .clk(clk), .rst(rst), .en(dir_en[d]), .vld(sample_vld),
      .hit(dir_hit[d]), .lim(dir_lim[d]), .fire(dir_fire[d])
    );
  end

  // ---------------- status and interrupt ----------------
  assign st_set = {dir_fire[0], dir_fire[1], ahi_hit && c.ahi_en, alo_hit && c.alo_en};
  assign st_clr = (reg_wr && wr_at(reg_addr, A_STAT)) ? reg_wdata[REG_W-1 -: ST_W] : '0;
  assign st_en  = {c.up_en, c.dn_en, c.ahi_en, c.alo_en};

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~st_clr) | st_set;
      irq    <= |(stat_q & st_en);
    end
  end

  // ---------------- read port ----------------
  logic [REG_W-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    case (reg_addr)
      ADDR_W'(A_CTRL):   rd_d = ctrl_q;
      ADDR_W'(A_UPWM):   rd_d[CNT_W-1:0] = up_wm_q;
      ADDR_W'(A_LOWM):   rd_d[CNT_W-1:0] = lo_wm_q;
      ADDR_W'(A_AHI):    rd_d[CNT_W-1:0] = ahi_q;
      ADDR_W'(A_ALO):    rd_d[CNT_W-1:0] = alo_q;
      ADDR_W'(A_WGT):    rd_d[WGT_W-1:0] = wgt_q;
      ADDR_W'(A_AVG):    rd_d[CNT_W-1:0] = avg;
      ADDR_W'(A_STAT):   rd_d[REG_W-1 -: ST_W] = stat_q;
      ADDR_W'(A_PERIOD): rd_d[PER_W-1:0] = per_q;
      default:           rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_d;
  end

  // R10: writing all ones to status with no new event leaves it empty
  a_r10_clear_all: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && wr_at(reg_addr, A_STAT) && (&reg_wdata[REG_W-1 -: ST_W]) && st_set == '0)
      |=> (stat_q == '0));

  // R10: a latched status bit stays until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && stat_q[3]) |=> stat_q[3]);

  // R11: with the master enable off no sample is ever produced afterwards
  a_r11_stopped: assert property (@(posedge clk) disable iff (rst)
    (!c.master && !$past(c.master)) |-> !sample_vld);
endmodule

// File: tb/sim_bus_activity_monitor.sv
`timescale 1ns/1ps
module sim_bus_activity_monitor;
  localparam int UC = 4;
  localparam int CW = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        event_in = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_activity_monitor #(.UNIT_CYCLES(UC), .PER_W(8), .CNT_W(CW), .WGT_W(16), .ADDR_W(4)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(event_in), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = 4'(a);
    tick();
    v = reg_rdata;
    reg_rd = 1'b0;
  endtask

  localparam logic [31:0] MST = 32'h8000_0000;
  localparam logic [31:0] UPE = 32'h4000_0000;
  localparam logic [31:0] DNE = 32'h2000_0000;
  localparam logic [31:0] AHE = 32'h0020_0000;
  localparam logic [31:0] ALE = 32'h0010_0000;
  localparam logic [31:0] PER = 32'h0004_0000;

  task automatic clean();
    event_in = 1'b0;
    wr(0, 32'h0);
    wr(8, 32'hFFFF_FFFF);
    wr(3, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(0, v); check("R1 ctrl", v, 32'h0);
    rd(8, v); check("R1 status", v, 32'h0);
    rd(7, v); check("R1 avg", v, 32'h0);
    rd(6, v); check("R1 weight", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(1, 32'h0001_2345); rd(1, v); check("R2 upper threshold", v, 32'h0001_2345);
    wr(6, 32'h0000_ABCD); rd(6, v); check("R2 weight", v, 32'h0000_ABCD);
    wr(9, 32'h0000_005A); rd(9, v); check("R2 period", v, 32'h0000_005A);
    wr(0, 32'h0000_0400); rd(0, v); check("R2 ctrl", v, 32'h0000_0400);
    wr(3, 32'd100);       rd(7, v); check("R6 load average", v, 32'd100);
    clean();
  endtask

  // one period of 8 cycles, weight 3, event every cycle -> sample 24
  task automatic t_above_irq();
    logic [31:0] v;
    wr(9, 32'd1); wr(6, 32'd3); wr(1, 32'd0); wr(4, 32'd5);
    event_in = 1'b1;
    wr(0, MST | UPE | AHE | PER);           // edge 0
    ticks(8);
    check("R10 irq before due edge", {31'b0, irq}, 32'h0);
    ticks(1);
    check("R10 irq still low at status edge", {31'b0, irq}, 32'h0);
    ticks(1);
    check("R10 irq raised", {31'b0, irq}, 32'h1);  // edge 10
    wr(0, 32'h0);                             // edge 11, stop before period 2
    event_in = 1'b0;
    rd(7, v); check("R3 R5 average 24>>1", v, 32'd12);
    rd(8, v); check("R7 R9 status above+avg above", v, 32'hA000_0000);
    tick();
    check("R10 irq masked by enables", {31'b0, irq}, 32'h0);
    wr(8, 32'h8000_0000);
    rd(8, v); check("R10 partial clear", v, 32'h2000_0000);
    wr(8, 32'hFFFF_FFFF);
    rd(8, v); check("R10 full clear", v, 32'h0);
    clean();
  endtask

  // K=1, no events: 100 -> 75 -> 56
  task automatic t_ema();
    logic [31:0] v;
    wr(9, 32'd1); wr(6, 32'd1); wr(5, 32'd80); wr(4, 32'hF_FFFF);
    wr(3, 32'd100);
    wr(0, MST | ALE | PER | 32'h0000_0400);  // edge 0
    ticks(17);
    wr(0, 32'h0);                             // edge 18
    rd(7, v); check("R5 two updates K=1", v, 32'd56);
    rd(8, v); check("R9 average below", v, 32'h1000_0000);
    clean();
  endtask

  // below threshold, N=3
  task automatic t_below_runs();
    logic [31:0] v;
    wr(9, 32'd1); wr(6, 32'd1); wr(2, 32'd1000);
    wr(0, MST | DNE | PER | (32'd2 << 23));
    ticks(17); wr(0, 32'h0);
    rd(8, v); check("R8 two periods not enough", v, 32'h0);
    wr(0, MST | DNE | PER | (32'd2 << 23));
    ticks(17); wr(0, 32'h0);
    rd(8, v); check("R11 run counter emptied by stop", v, 32'h0);
    wr(0, MST | DNE | PER | (32'd2 << 23));
    ticks(25); wr(0, 32'h0);
    rd(8, v); check("R8 three periods fire", v, 32'h4000_0000);
    clean();
  endtask

  // below threshold 10, N=2, weight 2: periods 0,16,0,0 -> fire after 4th
  task automatic t_below_break();
    logic [31:0] v;
    wr(9, 32'd1); wr(6, 32'd2); wr(2, 32'd10);
    wr(0, MST | DNE | PER | (32'd1 << 23)); // edge 0
    ticks(8);  event_in = 1'b1;               // cycles 9..16
    ticks(8);  event_in = 1'b0;
    ticks(10);
    rd(8, v); check("R8 run broken by busy period", v, 32'h0);   // edge 27
    ticks(6);
    rd(8, v); check("R8 fires after two quiet periods", v, 32'h4000_0000); // edge 34
    clean();
  endtask

  // saturation: 32 events of 0xFFFF overflow 20 bits
  task automatic t_saturate();
    logic [31:0] v;
    wr(9, 32'd7); wr(6, 32'h0000_FFFF);
    event_in = 1'b1;
    wr(0, MST | PER);                         // edge 0, period 32 cycles
    ticks(33);
    wr(0, 32'h0);                             // edge 34
    event_in = 1'b0;
    rd(7, v); check("R4 saturated sample", v, 32'd524287);
    clean();
  endtask

  initial begin
    ticks(3);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_above_irq();
    t_ema();
    t_below_runs();
    t_below_break();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule